// File: doc/BRIEF.md
# Microphone-side I2S serial data transmitter

This block is the sending end of a two-device I2S bus. A bus master supplies the bit clock and the word select. Within each word-select half-frame, the device that owns the slot puts a 24-bit two's complement sample on a data wire that both devices share. A strap input, `slot_sel`, chooses the slot. When it is 0 the block sends while word select is low. When it is 1 the block sends while word select is high. A second device uses the other slot on the same wire.

At the start of its own half-frame the block captures the parallel `sample` input, or zero while `mute` is high. It sends that word MSB first, with the MSB on the first bit-clock falling edge after the word-select change. The data line changes only on falling edges, so a receiver can sample on rising edges. The line is released right after the LSB. Its drive state is brought out as the enable `sdata_oe`, which would control an output pad.

The block measures every half-frame. Each one must last exactly 32 bit clocks, which makes a 64-clock frame. A half-frame of any other length raises `frame_err`. The flag holds through the following half-frame, and during that half-frame the block does not drive. The first half-frame after reset is never driven, because no length has been measured yet.

Top module: `i2s_mic_tx`

## Requirements
- R1: The word is sent MSB first. After the MSB, each later bit-clock falling edge presents the next lower bit, for 24 bits in total.
- R2: The MSB appears on `sdata`, with `sdata_oe` = 1, after the first bit-clock falling edge that follows a word-select change. Word select is sampled on rising edges.
- R3: With `slot_sel` = 0 the block drives only in half-frames where `wsel` = 0. With `slot_sel` = 1 it drives only where `wsel` = 1. In the other half-frame `sdata_oe` stays 0.
- R4: `sdata_oe` drops to 0 on the falling edge after the LSB, which is the 25th falling edge of the half-frame. It stays 0 for the rest of the frame. `sdata` reads 0 whenever `sdata_oe` is 0.
- R5: When a half-frame ends after any count of bit clocks other than 32, `frame_err` is 1 for the whole next half-frame and nothing is driven during it. A half-frame that ends before its word is complete stops its own transfer at the next word-select change.
- R6: When `mute` is 1 at the start of the block's half-frame, that word is sent as all zeros.
- R7: `sample` is captured only at the start of the block's own half-frame. Changes later in that half-frame do not alter the word being sent.
- R8: `sdata` and `sdata_oe` change only on bit-clock falling edges. They hold their value across rising edges.
- R9: While `rst_n` is 0, `sdata`, `sdata_oe` and `frame_err` are 0.
- R10: The first half-frame after reset is never driven, even when it is the block's own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the bus master |
| rst_n | input | 1 | Asynchronous active-low reset |
| wsel | input | 1 | Word select from the bus master (0 = left half, 1 = right half) |
| slot_sel | input | 1 | Strap choosing the half-frame to drive (0 = left, 1 = right) |
| mute | input | 1 | Forces the next captured word to zero |
| sample | input | SAMPLE_W | Parallel two's complement sample |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for the shared data wire |
| frame_err | output | 1 | Previous half-frame had the wrong length |

## Verification
The hardest case to reach from the ports is a half-frame that is cut short while the block is still sending its own word, because a well-behaved master never does this. The bench acts as the master, so it sets the length of every half-frame itself. Into a stream of normal 32-clock halves it places halves of 30, 34, 20 and 5 clocks, and the 20-clock half lands in the driving slot when `slot_sel` = 1. The bench also changes `sample` in the middle of every half-frame. Both strap values are swept, and the length sequence is the same for each.

// File: rtl/i2s_mic_pkg.sv
package i2s_mic_pkg;
    typedef enum logic {
        HALF_LEFT  = 1'b0,
        HALF_RIGHT = 1'b1
    } half_e;
endpackage

// File: rtl/mic_ws_sync.sv
module mic_ws_sync (
    input  logic bclk,
    input  logic rst_n,
    input  logic wsel,
    output logic ws_s
);
    logic ws_d, ws_q;

    always_comb begin
        ws_d = wsel;
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) ws_q <= 1'b0;
        else        ws_q <= ws_d;
    end

    assign ws_s = ws_q;
endmodule

// File: rtl/mic_slot_timer.sv
module mic_slot_timer
    import i2s_mic_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic                         bclk,
    input  logic                         rst_n,
    input  logic                         ws_s,
    input  logic                         slot_sel,
    output logic                         edge_o,
    output logic                         load_o,
    output logic                         half_ws_o,
    output logic                         frame_err_o,
    output logic [$clog2(SLOT_W+2)-1:0]  pos_o
);
    localparam int CW = $clog2(SLOT_W + 2);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_LEN = CW'(SLOT_W);

    typedef struct packed {
        half_e         ws_last;
        logic          synced;
        logic          err;
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t tm_d, tm_q;
    logic   edge_c, len_ok_c;

    always_comb begin
        tm_d     = tm_q;
        edge_c   = ws_s ^ tm_q.ws_last;
        len_ok_c = tm_q.synced && (tm_q.cnt == CNT_LEN);
        if (edge_c) begin
            tm_d.ws_last = half_e'(ws_s);
            tm_d.synced  = 1'b1;
            tm_d.err     = tm_q.synced && !len_ok_c;
            tm_d.cnt     = CW'(1);
        end else if (tm_q.cnt != CNT_MAX) begin
            tm_d.cnt = tm_q.cnt + 1'b1;
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) tm_q <= '{ws_last: HALF_LEFT, synced: 1'b0, err: 1'b0, cnt: '0};
        else        tm_q <= tm_d;
    end

    assign edge_o      = edge_c;
    assign load_o      = edge_c && len_ok_c && (ws_s == slot_sel);
    assign half_ws_o   = tm_q.ws_last;
    assign frame_err_o = tm_q.err;
    assign pos_o       = tm_q.cnt;
endmodule

// File: rtl/mic_word_shifter.sv
module mic_word_shifter #(
    parameter int SAMPLE_W = 24
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                edge_i,
    input  logic                load_i,
    input  logic                mute,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                sdata,
    output logic                sdata_oe
);
    localparam int LW = $clog2(SAMPLE_W + 1);

    typedef struct packed {
        logic [SAMPLE_W-1:0] sh;
        logic [LW-1:0]       left;
    } shift_t;

    shift_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d.sh   = mute ? '0 : sample;
            sr_d.left = LW'(SAMPLE_W);
        end else if (edge_i) begin
            sr_d.sh   = '0;
            sr_d.left = '0;
        end else if (sr_q.left != '0) begin
            sr_d.sh   = {sr_q.sh[SAMPLE_W-2:0], 1'b0};
            sr_d.left = sr_q.left - 1'b1;
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sdata_oe = (sr_q.left != '0);
    assign sdata    = sdata_oe & sr_q.sh[SAMPLE_W-1];

    // R6
    muted_msb_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        ($rose(sdata_oe) && $past(mute)) |-> !sdata);
endmodule

// File: rtl/i2s_mic_tx.sv
module i2s_mic_tx #(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                wsel,
    input  logic                slot_sel,
    input  logic                mute,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                sdata,
    output logic                sdata_oe,
    output logic                frame_err
);
    localparam int CW = $clog2(SLOT_W + 2);

    logic          ws_s, edge_w, load_w, half_ws;
    logic [CW-1:0] pos;

    mic_ws_sync u_sync (
        .bclk (bclk),
        .rst_n(rst_n),
        .wsel (wsel),
        .ws_s (ws_s)
    );

    mic_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .ws_s       (ws_s),
        .slot_sel   (slot_sel),
        .edge_o     (edge_w),
        .load_o     (load_w),
        .half_ws_o  (half_ws),
        .frame_err_o(frame_err),
        .pos_o      (pos)
    );

    mic_word_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
        .bclk    (bclk),
        .rst_n   (rst_n),
        .edge_i  (edge_w),
        .load_i  (load_w),
        .mute    (mute),
        .sample  (sample),
        .sdata   (sdata),
        .sdata_oe(sdata_oe)
    );

    // R3
    slot_owner_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        sdata_oe |-> (half_ws == slot_sel));

    // R2
    msb_delay_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        $rose(sdata_oe) |-> (pos == CW'(1)));

    // R4
    release_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        sdata_oe |-> (pos <= CW'(SAMPLE_W)));

    // R5
    err_quiet_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        frame_err |-> !sdata_oe);
endmodule

// File: tb/sim_i2s_mic_tx.sv
module sim_i2s_mic_tx;
    localparam int PERIOD = 20;
    localparam int Q      = PERIOD / 4;
    localparam int SW     = 24;
    localparam int HALFS  = 24;

    logic          bclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wsel = 1'b0;
    logic          slot_sel = 1'b0;
    logic          mute = 1'b0;
    logic [SW-1:0] sample = '0;
    logic          sdata, sdata_oe, frame_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit b_synced;
    int prevlen;
    logic last_oe, last_sd;

    i2s_mic_tx #(.SAMPLE_W(SW), .SLOT_W(32)) u0 (
        .bclk(bclk), .rst_n(rst_n), .wsel(wsel), .slot_sel(slot_sel),
        .mute(mute), .sample(sample), .sdata(sdata), .sdata_oe(sdata_oe),
        .frame_err(frame_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] pattern(input int j, input int lr);
        case (j % 6)
            0: return 24'h800000;
            1: return 24'h7FFFFF;
            2: return 24'h000001;
            3: return 24'hFFFFFF;
            default: return SW'(j * 32'h0035A7C3 + lr * 32'h123);
        endcase
    endfunction

    function automatic int half_len(input int j);
        case (j)
            10: return 30;
            13: return 34;
            16: return 20;
            19: return 5;
            default: return 32;
        endcase
    endfunction

    task automatic run_half(input int len, input bit wv, input logic [SW-1:0] smp, input bit mu);
        bit exp_ok, exp_err, unsynced, drive, e_oe;
        logic [SW-1:0] word;
        string t;
        exp_ok   = b_synced && prevlen == 32;
        exp_err  = b_synced && prevlen != 32;
        unsynced = !b_synced;
        b_synced = 1'b1;
        prevlen  = len;
        drive    = exp_ok && (wv == slot_sel);
        wsel     = wv;
        sample   = smp;
        mute     = mu;
        word     = mu ? '0 : smp;
        for (int p = 1; p <= len; p++) begin
            bclk = 1'b1;
            #Q;
            chk("R8 oe", {31'd0, sdata_oe}, {31'd0, last_oe});
            chk("R8 sd", {31'd0, sdata}, {31'd0, last_sd});
            #Q;
            bclk = 1'b0;
            #Q;
            e_oe = drive && p <= SW;
            if (unsynced)            t = "R10 oe";
            else if (exp_err)        t = "R5 oe";
            else if (wv != slot_sel) t = "R3 oe";
            else if (p == 1)         t = "R2 oe";
            else if (p > SW)         t = "R4 oe";
            else                     t = "R1 oe";
            chk(t, {31'd0, sdata_oe}, {31'd0, e_oe});
            chk("R5 err", {31'd0, frame_err}, {31'd0, exp_err});
            if (e_oe) begin
                if (mu)          t = "R6 sd";
                else if (p == 1) t = "R2 sd";
                else             t = "R1/R7 sd";
                chk(t, {31'd0, sdata}, {31'd0, word[SW-p]});
            end else begin
                chk("R4 sd idle", {31'd0, sdata}, 32'd0);
            end
            if (p == 1) sample = ~smp;
            last_oe = sdata_oe;
            last_sd = sdata;
            #Q;
        end
    endtask

    task automatic do_reset(input bit lr);
        rst_n    = 1'b0;
        wsel     = 1'b0;
        slot_sel = lr;
        mute     = 1'b0;
        sample   = '0;
        for (int k = 0; k < 4; k++) begin
            bclk = 1'b1; #(2*Q);
            bclk = 1'b0; #Q;
            chk("R9 oe", {31'd0, sdata_oe}, 32'd0);
            chk("R9 sd", {31'd0, sdata}, 32'd0);
            chk("R9 err", {31'd0, frame_err}, 32'd0);
            #Q;
        end
        rst_n    = 1'b1;
        b_synced = 1'b0;
        prevlen  = 0;
        last_oe  = 1'b0;
        last_sd  = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int lr = 0; lr < 2; lr++) begin
            bit wcur;
            do_reset(lr[0]);
            wcur = 1'b0;
            for (int j = 0; j < HALFS; j++) begin
                wcur = ~wcur;
                run_half(half_len(j), wcur, pattern(j, lr), (j == 6 || j == 7));
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule